// File: doc/BRIEF.md
# Keypad Status and Interrupt Unit

This block takes ten button lines, registers them, and presents them as a ten-bit status word. In the status word a pressed key reads 0 and a released key reads 1. A configuration input chooses how opposing directions are handled. When it is low, a simultaneous right+left press is reported as both released, and a simultaneous up+down press is treated the same way. The filtered key vector is what both the status word and the interrupt logic see.

A sixteen-bit control register chooses which keys take part in the interrupt. It also holds an enable bit and a combine mode: any selected key, or all selected keys. Only the defined bits are stored on a write. The interrupt condition is evaluated continuously from the registered keys and the stored control word. It is therefore re-evaluated when the keys change and again when the control register is written. The request output pulses for one cycle each time the condition goes from false to true.

Top module: `keypad_irq_unit`

## Requirements
- R1: While and right after reset, `key_status` is 0x3FF, `ctl_rdata` is 0x0000 and `irq` is 0.
- R2: One clock edge after `keys_raw` is applied, `key_status` equals 0x3FF XOR the (filtered) pressed vector, where `keys_raw[i]`=1 means key i is pressed and bit i of the status is key i.
- R3: With `allow_opposing` low, if keys 4 (right) and 5 (left) are both pressed, status bits 4 and 5 both read 1; other bits are unaffected.
- R4: With `allow_opposing` low, if keys 6 (up) and 7 (down) are both pressed, status bits 6 and 7 both read 1; other bits are unaffected.
- R5: With `allow_opposing` high, no suppression is applied; the status and the interrupt see the raw registered keys.
- R6: A write (`ctl_we`=1) stores `ctl_wdata & 0xC3FF`, which is visible on `ctl_rdata` after that edge; without a write the control word holds.
- R7: With control bit 14 (enable) set and bit 15 clear, the condition is true when at least one key selected by control bits 9:0 is pressed after filtering.
- R8: With bits 14 and 15 set, the condition is true only when the selection is non-empty and every selected key is pressed after filtering.
- R9: `irq` is high for exactly one cycle, in the cycle after the condition becomes true; a condition that stays true gives no further pulse.
- R10: A control write alone re-evaluates the condition: with the keys already held, a write that makes the condition true pulses `irq` in the cycle after the write.
- R11: With control bit 14 clear, `irq` never asserts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| keys_raw | input | 10 | Button lines, 1 = pressed |
| allow_opposing | input | 1 | High disables opposing-direction suppression |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 16 | Control register write data |
| key_status | output | 10 | Active-low key status |
| ctl_rdata | output | 16 | Stored control word |
| irq | output | 1 | One-cycle interrupt request pulse |

## Verification
Two paths can change the interrupt condition in the same clock edge: a new key sample and a control write. The bench provokes this by writing the control word and changing the keys in the same cycle. Some of these writes disable the interrupt while a qualifying key arrives, and others enable it while the keys leave. Flipping `allow_opposing` while both directions of a pair are held also moves the condition without any key edge. A behavioural model, which takes both updates at the edge and then evaluates the condition once, judges every cycle: status, control read-back and the exact cycle of each pulse.

// File: rtl/kp_pkg.sv
package kp_pkg;
   localparam int KP_NUM_KEYS   = 10;
   localparam int KP_CTL_W      = 16;
   localparam int KP_RIGHT_BIT  = 4;
   localparam int KP_LEFT_BIT   = 5;
   localparam int KP_UP_BIT     = 6;
   localparam int KP_DOWN_BIT   = 7;
   localparam int KP_EN_BIT     = 14;
   localparam int KP_ALL_BIT    = 15;

   function automatic logic [KP_CTL_W-1:0] kp_ctl_mask(input int nkeys);
      logic [KP_CTL_W-1:0] m;
      m = '0;
      m[KP_EN_BIT]  = 1'b1;
      m[KP_ALL_BIT] = 1'b1;
      for (int i = 0; i < nkeys; i++) m[i] = 1'b1;
      return m;
   endfunction
endpackage

// File: rtl/kp_sampler.sv
module kp_sampler #(
   parameter int NUM_KEYS    = 10,
   parameter int SYNC_STAGES = 1,
   parameter bit FILTER_EN   = 1'b1,
   parameter int RIGHT_BIT   = 4,
   parameter int LEFT_BIT    = 5,
   parameter int UP_BIT      = 6,
   parameter int DOWN_BIT    = 7
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_KEYS-1:0] keys_raw,
   input  logic                allow_opposing,
   output logic [NUM_KEYS-1:0] pressed_o
);
   localparam int LAST = SYNC_STAGES - 1;

   if (SYNC_STAGES < 1) begin : g_bad_stages
      $error("kp_sampler: SYNC_STAGES must be at least 1");
   end
   if (RIGHT_BIT >= NUM_KEYS || LEFT_BIT >= NUM_KEYS ||
       UP_BIT >= NUM_KEYS || DOWN_BIT >= NUM_KEYS) begin : g_bad_pos
      $error("kp_sampler: direction bit outside key vector");
   end

   for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
      logic [NUM_KEYS-1:0] q;
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= '0;
            else        q <= keys_raw;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= '0;
            else        q <= g_stage[s-1].q;
         end
      end
   end

   logic [NUM_KEYS-1:0] sampled;
   assign sampled = g_stage[LAST].q;

   if (FILTER_EN) begin : g_filter
      always_comb begin
         pressed_o = sampled;
         if (!allow_opposing) begin
            if (sampled[RIGHT_BIT] && sampled[LEFT_BIT]) begin
               pressed_o[RIGHT_BIT] = 1'b0;
               pressed_o[LEFT_BIT]  = 1'b0;
            end
            if (sampled[UP_BIT] && sampled[DOWN_BIT]) begin
               pressed_o[UP_BIT]   = 1'b0;
               pressed_o[DOWN_BIT] = 1'b0;
            end
         end
      end

      p_lr_suppress_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (!allow_opposing && sampled[RIGHT_BIT] && sampled[LEFT_BIT])
            |-> (!pressed_o[RIGHT_BIT] && !pressed_o[LEFT_BIT]));
      p_ud_suppress_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (!allow_opposing && sampled[UP_BIT] && sampled[DOWN_BIT])
            |-> (!pressed_o[UP_BIT] && !pressed_o[DOWN_BIT]));
      p_passthru_r5: assert property (@(posedge clk) disable iff (!rst_n)
         allow_opposing |-> (pressed_o == sampled));
   end else begin : g_nofilter
      logic unused_allow;
      assign unused_allow = allow_opposing;
      assign pressed_o = sampled;
   end
endmodule

// File: rtl/kp_ctl_reg.sv
module kp_ctl_reg #(
   parameter int               CTL_W = 16,
   parameter logic [CTL_W-1:0] MASK  = 16'hC3FF
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [CTL_W-1:0] wdata,
   output logic [CTL_W-1:0] ctl_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  ctl_q <= '0;
      else if (we) ctl_q <= wdata & MASK;
   end

   p_write_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (ctl_q == ($past(wdata) & MASK)));
   p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(ctl_q));
endmodule

// File: rtl/kp_irq_eval.sv
module kp_irq_eval #(
   parameter int NUM_KEYS = 10
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_KEYS-1:0] pressed,
   input  logic [NUM_KEYS-1:0] sel,
   input  logic                en,
   input  logic                all_mode,
   output logic                irq
);
   logic [NUM_KEYS-1:0] hit;
   logic any_hit, all_hit, cond, cond_q;

   assign hit     = pressed & sel;
   assign any_hit = |hit;
   assign all_hit = (|sel) && (hit == sel);
   assign cond    = en && (all_mode ? all_hit : any_hit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cond_q <= 1'b0;
      else        cond_q <= cond;
   end

   assign irq = cond && !cond_q;

   p_single_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);
   p_disabled_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> !irq);
   p_all_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (all_mode && irq) |-> ((pressed & sel) == sel && sel != '0));
endmodule

// File: rtl/keypad_irq_unit.sv
module keypad_irq_unit
   import kp_pkg::*;
#(
   parameter int NUM_KEYS    = KP_NUM_KEYS,
   parameter int SYNC_STAGES = 1,
   parameter bit FILTER_EN   = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_KEYS-1:0] keys_raw,
   input  logic                allow_opposing,
   input  logic                ctl_we,
   input  logic [KP_CTL_W-1:0] ctl_wdata,
   output logic [NUM_KEYS-1:0] key_status,
   output logic [KP_CTL_W-1:0] ctl_rdata,
   output logic                irq
);
   localparam logic [KP_CTL_W-1:0] CTL_MASK = kp_ctl_mask(NUM_KEYS);
   localparam logic [NUM_KEYS-1:0] ALL_UP   = '1;

   if (NUM_KEYS < 8 || NUM_KEYS > KP_EN_BIT) begin : g_bad_keys
      $error("keypad_irq_unit: NUM_KEYS must lie between 8 and 14");
   end

   logic [NUM_KEYS-1:0] pressed;
   logic [KP_CTL_W-1:0] ctl_q;

   kp_sampler #(
      .NUM_KEYS(NUM_KEYS), .SYNC_STAGES(SYNC_STAGES), .FILTER_EN(FILTER_EN),
      .RIGHT_BIT(KP_RIGHT_BIT), .LEFT_BIT(KP_LEFT_BIT),
      .UP_BIT(KP_UP_BIT), .DOWN_BIT(KP_DOWN_BIT)
   ) u_sampler (
      .clk(clk), .rst_n(rst_n), .keys_raw(keys_raw),
      .allow_opposing(allow_opposing), .pressed_o(pressed)
   );

   kp_ctl_reg #(.CTL_W(KP_CTL_W), .MASK(CTL_MASK)) u_ctl (
      .clk(clk), .rst_n(rst_n), .we(ctl_we), .wdata(ctl_wdata), .ctl_q(ctl_q)
   );

   kp_irq_eval #(.NUM_KEYS(NUM_KEYS)) u_irq (
      .clk(clk), .rst_n(rst_n), .pressed(pressed),
      .sel(ctl_q[NUM_KEYS-1:0]), .en(ctl_q[KP_EN_BIT]),
      .all_mode(ctl_q[KP_ALL_BIT]), .irq(irq)
   );

   assign key_status = ALL_UP ^ pressed;
   assign ctl_rdata  = ctl_q;

   p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (ctl_rdata == '0 && !irq));
endmodule

// File: tb/keypad_irq_unit_test.sv
module keypad_irq_unit_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [9:0]  keys_raw = '0;
   logic        allow_opposing = 1'b0;
   logic        ctl_we = 1'b0;
   logic [15:0] ctl_wdata = '0;
   logic [9:0]  key_status;
   logic [15:0] ctl_rdata;
   logic        irq;

   int checks = 0;
   int fails  = 0;

   // reference state
   int m_keys = 0;
   int m_ctl  = 0;
   bit m_prev = 0;

   always #5 clk = ~clk;

   keypad_irq_unit uut (
      .clk(clk), .rst_n(rst_n), .keys_raw(keys_raw),
      .allow_opposing(allow_opposing), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
      .key_status(key_status), .ctl_rdata(ctl_rdata), .irq(irq)
   );

   function automatic int filt(input int k, input bit allow);
      int p = k;
      if (!allow) begin
         if (((p >> 4) & 3) == 3) p = p & ~32'h30;
         if (((p >> 6) & 3) == 3) p = p & ~32'hC0;
      end
      return p;
   endfunction

   function automatic bit cond_of(input int k, input int c, input bit allow);
      int p   = filt(k, allow);
      int sel = c & 32'h3FF;
      if (((c >> 14) & 1) == 0) return 0;
      if (((c >> 15) & 1) == 1) return (sel != 0) && ((p & sel) == sel);
      return (p & sel) != 0;
   endfunction

   // reference model: update at each edge from stable inputs
   always @(posedge clk) begin
      if (!rst_n) begin
         m_keys = 0; m_ctl = 0; m_prev = 0;
      end else begin
         m_prev = cond_of(m_keys, m_ctl, allow_opposing);
         m_keys = int'(keys_raw);
         if (ctl_we) m_ctl = int'(ctl_wdata) & 32'hC3FF;
      end
   end

   // compare away from the active edge
   always @(negedge clk) begin
      int exp_st;
      bit exp_irq;
      if (!rst_n) begin
         checks++;
         if (key_status !== 10'h3FF || ctl_rdata !== 16'h0 || irq !== 1'b0) begin
            fails++;
            $display("FAIL R1 reset: status=%h ctl=%h irq=%b expected 3ff 0000 0",
                     key_status, ctl_rdata, irq);
         end
      end else begin
         exp_st  = 32'h3FF ^ filt(m_keys, allow_opposing);
         exp_irq = cond_of(m_keys, m_ctl, allow_opposing) && !m_prev;
         checks++;
         if (int'(key_status) != exp_st) begin
            fails++;
            $display("FAIL R2/R3/R4/R5 status: actual %h expected %h", key_status, exp_st[9:0]);
         end
         checks++;
         if (int'(ctl_rdata) != m_ctl) begin
            fails++;
            $display("FAIL R6 control: actual %h expected %h", ctl_rdata, m_ctl[15:0]);
         end
         checks++;
         if (irq !== exp_irq) begin
            fails++;
            $display("FAIL R7/R8/R9/R10/R11 irq: actual %b expected %b", irq, exp_irq);
         end
      end
   end

   task automatic drive(input logic [9:0] k, input bit a, input bit we, input logic [15:0] wd);
      @(posedge clk);
      #2;
      keys_raw = k; allow_opposing = a; ctl_we = we; ctl_wdata = wd;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) drive(keys_raw, allow_opposing, 1'b0, 16'h0);
   endtask

   initial begin : watchdog
      #2000000;
      fails++;
      $display("FAIL watchdog expired: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks + 1);
      $finish;
   end

   initial begin
      int lfsr = 32'h1ACE;
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      idle(2);
      // R2: single keys
      drive(10'h001, 0, 0, 0); drive(10'h200, 0, 0, 0); drive(10'h000, 0, 0, 0);
      // R3 / R4 / R5: opposing pairs, filter on then off
      drive(10'h031, 0, 0, 0); drive(10'h0C2, 0, 0, 0); drive(10'h0F0, 0, 0, 0);
      drive(10'h0F0, 1, 0, 0); drive(10'h030, 1, 0, 0); drive(10'h030, 0, 0, 0);
      // R6: masked write, then hold
      drive(10'h000, 0, 1, 16'hFFFF); idle(2);
      drive(10'h000, 0, 1, 16'h3C00); idle(1);
      // R7 / R9: any-key mode
      drive(10'h000, 0, 1, 16'h4003); idle(1);
      drive(10'h002, 0, 0, 0); idle(3);
      drive(10'h003, 0, 0, 0); drive(10'h000, 0, 0, 0); drive(10'h001, 0, 0, 0); idle(2);
      // R8: all-key mode
      drive(10'h000, 0, 1, 16'hC003); drive(10'h001, 0, 0, 0); idle(1);
      drive(10'h003, 0, 0, 0); idle(2);
      drive(10'h000, 0, 1, 16'hC000); drive(10'h3FF, 0, 0, 0); idle(1);
      // R10: write with keys already held
      drive(10'h008, 0, 0, 0); idle(2);
      drive(10'h008, 0, 1, 16'h4008); idle(2);
      // R11: enable clear
      drive(10'h000, 0, 1, 16'h0008); drive(10'h008, 0, 0, 0); idle(2);
      // R8 with filtered pair, then opposing allowed
      drive(10'h030, 0, 1, 16'hC030); idle(2);
      drive(10'h030, 1, 0, 0); idle(1); drive(10'h030, 0, 0, 0); drive(10'h030, 1, 0, 0);
      // same-cycle control write and key change
      drive(10'h000, 0, 1, 16'h0000);
      drive(10'h004, 0, 1, 16'h4004); idle(1);
      drive(10'h000, 0, 1, 16'h0004);
      drive(10'h004, 0, 1, 16'h4004);
      drive(10'h008, 0, 1, 16'h4004);
      drive(10'h004, 0, 1, 16'h0004); idle(1);
      // pseudo-random mix
      for (int i = 0; i < 400; i++) begin
         lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB4BCD35C : 0);
         drive(lfsr[9:0], lfsr[12], (lfsr[15:13] == 3'd0), {lfsr[31:30], 4'h0, lfsr[25:16]});
      end
      idle(3);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule